// File: doc/BRIEF.md
# Row-Latched SRAM Access Controller

This block is the control logic and datapath around a word-addressed data memory. Its storage is built from wide rows grouped into banks. Every array read brings a whole row into a wide holding latch. The latch keeps a tag that names the row it holds. When a later read names the same row, the block spots this by itself and returns the word straight from the latch. On such a read it raises no decode enable and no wordline strobe, so the read costs little energy.

A write never needs a separate read cycle. The block fetches the target row under a read strobe and merges the new word into it. It then drives the merged row back under a write strobe, all within one access. Two external margin inputs set how many clock cycles each strobe lasts. After the write, the latch holds the merged row, so a following read of that row is a hit that returns the new data. The host uses a valid/ready request handshake. Read data comes back with a one-cycle response flag, and a one-cycle class pulse marks each finished access. A counter records how many accesses reached the array.

Top module: `rowLatchSram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, reqReady is 1, every class pulse and rspValid are 0, arrayAccessCount is 0 and the latch is empty. The first read after reset therefore always goes to the array.
- R2: The word address splits into a bank in bits [10:9], a row in bits [8:3] and a word-in-row in bits [2:0]. Each of the 2048 addresses stores its own 16-bit word, and the array powers up as all zeros.
- R3: A read that misses the latch holds decodeEn and rdWordline high for rdPulseCfg+1 cycles, starting the cycle after it is accepted, while reqReady is low. In the cycle after that, rspValid and accArray are 1 for one cycle and rspData holds the addressed word.
- R4: A read that hits the latch is answered in the cycle after it is accepted, with rspValid and accLowEnergy. During that access decodeEn, rdWordline and wrWordline stay 0 and reqReady stays 1.
- R5: After one array read of a row, reads of the other seven words of that row are all answered as latch hits.
- R6: A write holds decodeEn and rdWordline for rdPulseCfg+1 cycles, then decodeEn and wrWordline for wrPulseCfg+1 cycles. rdWordline and wrWordline are never high together. In the next cycle accWriteBack pulses and reqReady returns to 1. A write produces no rspValid.
- R7: A write changes only the addressed word. The other seven words of its row keep their values.
- R8: After a write, the latch holds the merged row tagged with the written row. A following read anywhere in that row is a latch hit that returns the current data.
- R9: A read of a different row is a miss and replaces the latch contents. This includes the same row index in another bank.
- R10: arrayAccessCount rises by exactly 1 for each array read and each write, in the cycle its class pulse shows. A latch hit leaves it unchanged.
- R11: accArray, accLowEnergy and accWriteBack are never high together. Each stays high for one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | Word address |
| reqWdata | input | 16 | Write data |
| rdPulseCfg | input | 4 | Read-strobe length minus one, in cycles; hold during an access |
| wrPulseCfg | input | 4 | Write-strobe length minus one, in cycles; hold during an access |
| reqReady | output | 1 | Request accepted when high with reqValid |
| rspValid | output | 1 | Read data valid, one cycle |
| rspData | output | 16 | Read data |
| decodeEn | output | 1 | Row/bank decode enable |
| rdWordline | output | 1 | Read-phase wordline strobe |
| wrWordline | output | 1 | Write-phase wordline strobe |
| accArray | output | 1 | Pulse: array read finished |
| accLowEnergy | output | 1 | Pulse: latch-hit read finished |
| accWriteBack | output | 1 | Pulse: write-after-read finished |
| arrayAccessCount | output | 16 | Count of accesses that reached the array |

## Verification
Two functions meet in a single cycle when a read of a row arrives right after a write to that row. The same cycle both finishes the write-back and, as the next request is accepted, checks the freshly retagged latch for a hit. The bench issues such reads with no gap after writes, with strobe widths from zero up. It expects a hit that carries the merged data, with decode and wordlines silent. A hit also falls at once on an array read that has just refilled the latch from another bank with the same row index. The bench judges that case by the data returned and by the class pulse.

// File: rtl/rowLatchPkg.sv
package rowLatchPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // request taken this cycle
    logic serveLatch; // read hit answered from latch
    logic capture;    // end of read phase: load latch
    logic commit;     // end of write phase: store latch row
    logic isWrite;    // current array access is a write
    logic decodeEn;
    logic rdWl;
    logic wrWl;
  } strobe_t;

endpackage

// File: rtl/rowLatchCtrl.sv
module rowLatchCtrl
  import rowLatchPkg::*;
#(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             hit,
  input  logic [CFG_W-1:0] rdPulseCfg,
  input  logic [CFG_W-1:0] wrPulseCfg,
  output logic             reqReady,
  output strobe_t          stb
);

  ctrlState_t       state;
  logic [CFG_W-1:0] phaseCnt;
  logic             writeQ;
  logic             lastCycle;

  assign lastCycle = (phaseCnt == '0);

  always_comb begin
    stb      = '0;
    reqReady = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        stb.accept     = reqValid;
        stb.serveLatch = reqValid && !reqWrite && hit;
      end
      ST_READ: begin
        stb.decodeEn = 1'b1;
        stb.rdWl     = 1'b1;
        stb.capture  = lastCycle;
        stb.isWrite  = writeQ;
      end
      ST_WRITE: begin
        stb.decodeEn = 1'b1;
        stb.wrWl     = 1'b1;
        stb.commit   = lastCycle;
        stb.isWrite  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      writeQ   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid && (reqWrite || !hit)) begin
            state    <= ST_READ;
            phaseCnt <= rdPulseCfg;
            writeQ   <= reqWrite;
          end
        end
        ST_READ: begin
          if (lastCycle) begin
            if (writeQ) begin
              state    <= ST_WRITE;
              phaseCnt <= wrPulseCfg;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (lastCycle) state <= ST_IDLE;
          else           phaseCnt <= phaseCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rowLatchDatapath.sv
module rowLatchDatapath
  import rowLatchPkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int WORD_W   = 16,
  parameter int ROW_WORDS = 8,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              hit,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              decodeEn,
  output logic              rdWordline,
  output logic              wrWordline,
  output logic              accArray,
  output logic              accLowEnergy,
  output logic              accWriteBack,
  output logic [CNT_W-1:0]  arrayAccessCount
);

  localparam int SEL_W = $clog2(ROW_WORDS);
  localparam int ROW_W = WORD_W * ROW_WORDS;
  localparam int TAG_W = ADDR_W - SEL_W;
  localparam int ROWS  = 2 ** TAG_W;

  logic [ROW_W-1:0]  rowMem [ROWS];
  logic [ROW_W-1:0]  latchRow;
  logic [TAG_W-1:0]  latchTag;
  logic              latchValid;
  logic [TAG_W-1:0]  tagQ;
  logic [SEL_W-1:0]  selQ;
  logic [WORD_W-1:0] dataQ;
  logic [ROW_W-1:0]  mergedRow;
  logic              arrayRead;

  assign hit        = latchValid && (latchTag == reqAddr[ADDR_W-1:SEL_W]);
  assign decodeEn   = stb.decodeEn;
  assign rdWordline = stb.rdWl;
  assign wrWordline = stb.wrWl;
  assign arrayRead  = stb.capture && !stb.isWrite;

  always_comb begin
    mergedRow = rowMem[tagQ];
    if (stb.isWrite) mergedRow[selQ*WORD_W +: WORD_W] = dataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) rowMem[r] <= '0;
      latchRow         <= '0;
      latchTag         <= '0;
      latchValid       <= 1'b0;
      tagQ             <= '0;
      selQ             <= '0;
      dataQ            <= '0;
      rspValid         <= 1'b0;
      rspData          <= '0;
      accArray         <= 1'b0;
      accLowEnergy     <= 1'b0;
      accWriteBack     <= 1'b0;
      arrayAccessCount <= '0;
    end else begin
      rspValid     <= stb.serveLatch || arrayRead;
      accArray     <= arrayRead;
      accLowEnergy <= stb.serveLatch;
      accWriteBack <= stb.commit;
      if (arrayRead || stb.commit) arrayAccessCount <= arrayAccessCount + 1'b1;
      if (stb.accept) begin
        tagQ  <= reqAddr[ADDR_W-1:SEL_W];
        selQ  <= reqAddr[SEL_W-1:0];
        dataQ <= reqWdata;
      end
      if (stb.serveLatch) rspData <= latchRow[reqAddr[SEL_W-1:0]*WORD_W +: WORD_W];
      if (stb.capture) begin
        latchRow   <= mergedRow;
        latchTag   <= tagQ;
        latchValid <= 1'b1;
        if (!stb.isWrite) rspData <= mergedRow[selQ*WORD_W +: WORD_W];
      end
      if (stb.commit) rowMem[tagQ] <= latchRow;
    end
  end

endmodule

// File: rtl/rowLatchSram.sv
module rowLatchSram
  import rowLatchPkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WORD_W    = 16,
  parameter int ROW_WORDS = 8,
  parameter int CFG_W     = 4,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [CFG_W-1:0]  rdPulseCfg,
  input  logic [CFG_W-1:0]  wrPulseCfg,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              decodeEn,
  output logic              rdWordline,
  output logic              wrWordline,
  output logic              accArray,
  output logic              accLowEnergy,
  output logic              accWriteBack,
  output logic [CNT_W-1:0]  arrayAccessCount
);

  strobe_t stb;
  logic    hit;

  rowLatchCtrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(hit), .rdPulseCfg(rdPulseCfg), .wrPulseCfg(wrPulseCfg),
    .reqReady(reqReady), .stb(stb)
  );

  rowLatchDatapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .hit(hit), .rspValid(rspValid), .rspData(rspData), .decodeEn(decodeEn),
    .rdWordline(rdWordline), .wrWordline(wrWordline), .accArray(accArray),
    .accLowEnergy(accLowEnergy), .accWriteBack(accWriteBack),
    .arrayAccessCount(arrayAccessCount)
  );

endmodule

// File: rtl/rowLatchChecker.sv
module rowLatchChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             rspValid,
  input logic             decodeEn,
  input logic             rdWordline,
  input logic             wrWordline,
  input logic             accArray,
  input logic             accLowEnergy,
  input logic             accWriteBack,
  input logic [CNT_W-1:0] arrayAccessCount
);

  assert_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    accLowEnergy |-> (!decodeEn && !rdWordline && !wrWordline && reqReady));

  assert_hit_prev_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    accLowEnergy |-> !$past(decodeEn));

  assert_wl_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdWordline && wrWordline));

  assert_wl_needs_decode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdWordline || wrWordline) |-> (decodeEn && !reqReady));

  assert_wb_after_wl_R6: assert property (@(posedge clk) disable iff (!rstN)
    accWriteBack |-> ($past(wrWordline) && !rspValid));

  assert_rsp_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (accArray || accLowEnergy));

  assert_class_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accArray, accLowEnergy, accWriteBack}));

  assert_array_pulse_once_R11: assert property (@(posedge clk) disable iff (!rstN)
    accArray |=> !accArray);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accArray || accWriteBack) |-> (arrayAccessCount == $past(arrayAccessCount) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(accArray || accWriteBack) |-> $stable(arrayAccessCount));

endmodule

bind rowLatchSram rowLatchChecker #(.CNT_W(CNT_W)) i_checker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .decodeEn(decodeEn), .rdWordline(rdWordline), .wrWordline(wrWordline),
  .accArray(accArray), .accLowEnergy(accLowEnergy), .accWriteBack(accWriteBack),
  .arrayAccessCount(arrayAccessCount)
);

// File: tb/test_rowLatchSram.sv
`timescale 1ns/1ps
module test_rowLatchSram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [3:0]  rdPulseCfg = '0;
  logic [3:0]  wrPulseCfg = '0;
  logic        reqReady, rspValid, decodeEn, rdWordline, wrWordline;
  logic        accArray, accLowEnergy, accWriteBack;
  logic [15:0] rspData, arrayAccessCount;

  always #10 clk = ~clk;

  rowLatchSram i_rowLatchSram (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdPulseCfg(rdPulseCfg),
    .wrPulseCfg(wrPulseCfg), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .decodeEn(decodeEn), .rdWordline(rdWordline),
    .wrWordline(wrWordline), .accArray(accArray), .accLowEnergy(accLowEnergy),
    .accWriteBack(accWriteBack), .arrayAccessCount(arrayAccessCount)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model
  logic [15:0] refMem [2048];
  bit          refValid = 0;
  logic [7:0]  refTag = '0;
  int          refCount = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // {ready, decodeEn, rdWl, wrWl, rspValid, accArray, accLowEnergy, accWriteBack}
  task automatic expectCycle(input logic [7:0] exp, input logic [15:0] data, input string tag);
    logic [7:0] act;
    act = {reqReady, decodeEn, rdWordline, wrWordline, rspValid, accArray, accLowEnergy, accWriteBack};
    check(act === exp, tag, {24'd0, act}, {24'd0, exp});
    if (exp[3]) check(rspData === data, {tag, " data"}, {16'd0, rspData}, {16'd0, data});
  endtask

  // starts and ends at a negedge
  task automatic access(input bit wr, input logic [10:0] a, input logic [15:0] d,
                        input int rc, input int wc, input string tag);
    bit isHit;
    isHit = !wr && refValid && (refTag == a[10:3]);
    rdPulseCfg = 4'(rc);
    wrPulseCfg = 4'(wc);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr = a;
    reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (isHit) begin
      expectCycle(8'b1000_1010, refMem[a], {tag, " hit R4"});
    end else begin
      for (int k = 0; k <= rc; k++) begin
        expectCycle(8'b0110_0000, '0, {tag, " read phase R3 R6"});
        @(negedge clk);
      end
      refValid = 1;
      refTag = a[10:3];
      refCount++;
      if (wr) begin
        refMem[a] = d;
        for (int k = 0; k <= wc; k++) begin
          expectCycle(8'b0101_0000, '0, {tag, " write phase R6"});
          @(negedge clk);
        end
        expectCycle(8'b1000_0001, '0, {tag, " write done R6"});
      end else begin
        expectCycle(8'b1000_1100, refMem[a], {tag, " array read R3 R9"});
      end
    end
    check(arrayAccessCount === 16'(refCount), {tag, " count R10"},
          {16'd0, arrayAccessCount}, refCount);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    for (int i = 0; i < 2048; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    expectCycle(8'b1000_0000, '0, "reset R1");
    rstN = 1'b1;
    @(negedge clk);
    expectCycle(8'b1000_0000, '0, "after reset R1");
    check(arrayAccessCount === 16'd0, "count reset R1", {16'd0, arrayAccessCount}, 0);

    access(0, 11'h010, '0, 0, 0, "first read miss R1");
    access(1, 11'h013, 16'hBEEF, 1, 2, "write R6");
    access(0, 11'h013, '0, 0, 0, "read after write R8");
    for (int w = 0; w < 8; w++)
      if (w != 3) access(0, 11'h010 + 11'(w), '0, 0, 0, "row neighbours R5 R7");

    access(1, 11'h215, 16'h1234, 0, 0, "write bank1 R2");
    access(0, 11'h215, '0, 0, 0, "hit bank1 R8");
    access(0, 11'h015, '0, 2, 0, "other bank same row R9");
    access(0, 11'h013, '0, 0, 0, "hit restored R5");

    for (int i = 0; i < 12; i++)
      access(1, 11'((i * 173) % 2048), 16'(16'hA000 + i * 7), i % 3, (i + 1) % 3, "write sweep R7");
    for (int i = 0; i < 12; i++) begin
      access(0, 11'((i * 173) % 2048), '0, 1, 0, "read sweep R2");
      access(0, 11'((i * 173) % 2048) ^ 11'h001, '0, 0, 0, "read sweep neighbour R5");
    end
    access(1, 11'h7FF, 16'hFFFF, 3, 3, "wide strobes R6");
    access(0, 11'h7F8, '0, 0, 0, "top row R7");
    access(0, 11'h7FF, '0, 0, 0, "top word R8");

    @(negedge clk);
    expectCycle(8'b1000_0000, '0, "idle R11");
    finish();
  end

endmodule